// File: doc/BRIEF.md
# Inter-Core Message Doorbell

This block lets any core in a system of `N_CORES` processors interrupt another core and hand it a 16-bit message in the same step. Every core owns an 8-byte window on a plain 32-bit register bus. The first word of the window is a command word that the core writes. The second word is a mailbox word that the core reads. To send, a core writes its own command word with the send flag, a destination index and a payload. The mailbox of the destination then records that a message is waiting, which core sent it, and the payload.

Each core has one level interrupt line. The line stays high while that core's mailbox holds an unacknowledged message. To clear it, the core writes its own command word with the acknowledge flag. The block has no interrupt inputs: register writes are the only way a message can arrive. Accesses are whole 32-bit words with the bit numbering below. Bit 31 is the most significant bit of the word as it appears on the bus.

Top module: `ipi_mailbox`

## Requirements
- R1: After a synchronous active-low reset, every mailbox word reads zero and every interrupt line is low.
- R2: A write to command word `c` (byte address `c*8`) with bit 30 set loads the mailbox of destination `d` = bits 29..16 on the next clock edge. The mailbox (byte address `d*8+4`) then holds bit 30 = 1, bits 29..16 = `c`, and bits 15..0 = the written bits 15..0.
- R3: Interrupt line `d` is high exactly while the mailbox of `d` has bit 30 set. It stays high with no further bus activity.
- R4: A write to command word `c` with bit 31 set clears bit 30 of mailbox `c` only. The sender and payload fields of that mailbox are kept, and the other mailboxes are untouched.
- R5: A send whose destination index is `N_CORES` or higher changes no state.
- R6: A send to a mailbox that already has a message waiting replaces its sender and payload, and the mailbox stays pending.
- R7: When one write sets both bit 31 and bit 30, the acknowledge is applied first and the send second. A core that sends to itself this way stays pending with the new message.
- R8: Reading a command word returns zero. Bit 31 of a mailbox word always reads zero.
- R9: Writes to mailbox words have no effect.
- R10: A command write with neither bit 31 nor bit 30 set has no effect.
- R11: An access whose address bits 1..0 are not zero is ignored on write and reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address (`ADDR_W` = core-index width + 3) |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq_o | output | N_CORES | Level interrupt per core |

## Verification
The assertions run on every cycle and cover four properties:
- An interrupt line only rises after a send and only falls after an acknowledge.
- A write to a mailbox word, or a send to an out-of-range destination, leaves every line as it was.
- Command words read zero, and the reserved mailbox bit reads zero.
- Reset drops all lines.

Some behaviour is visible only in the bench's scenarios, which read the mailbox contents back:
- that the sender index and payload are recorded exactly;
- that an overwrite keeps the pending state;
- that the acknowledge-then-send order works for both self-targeted and foreign destinations;
- that no-op and misaligned writes leave the fields intact.

// File: rtl/ipi_mbox_pkg.sv
// Package: shared field positions and the mailbox record type for the
// inter-core doorbell. Assumes 32-bit word accesses.
package ipi_mbox_pkg;

    localparam int WORD_W   = 32;
    localparam int IDX_W    = 14;  // width of sender/destination fields
    localparam int DATA_W   = 16;

    localparam int BIT_ACK  = 31;
    localparam int BIT_SEND = 30;
    localparam int IDX_LSB  = 16;
    localparam int IDX_MSB  = IDX_LSB + IDX_W - 1;

    typedef struct packed {
        logic              pend;
        logic [IDX_W-1:0]  src;
        logic [DATA_W-1:0] data;
    } mbox_t;

    // Packs a mailbox record into its bus word; bit 31 is reserved zero.
    function automatic logic [WORD_W-1:0] mbox_word(input mbox_t m);
        return {1'b0, m.pend, m.src, m.data};
    endfunction

endpackage

// File: rtl/ipi_bus_decode.sv
// Module: splits a bus access into a command-word write from one core and
// the fields of that command. Assumes byte addresses with the core index
// above bit 2 and word alignment required.
module ipi_bus_decode
    import ipi_mbox_pkg::*;
#(
    parameter int N_CORES = 4,
    localparam int CORE_W = (N_CORES > 1) ? $clog2(N_CORES) : 1,
    localparam int ADDR_W = CORE_W + 3
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic              aligned,
    output logic              core_ok,
    output logic              sel_mbox,
    output logic [CORE_W-1:0] acc_core,
    output logic              cmd_wr,
    output logic              cmd_ack,
    output logic              cmd_send,
    output logic [CORE_W-1:0] dst_core,
    output logic [DATA_W-1:0] cmd_data
);

    logic [IDX_W-1:0] dst_raw;
    logic             dst_ok;

    assign acc_core = bus_addr[ADDR_W-1:3];
    assign sel_mbox = bus_addr[2];
    assign aligned  = (bus_addr[1:0] == 2'b00);

    // Range check of the accessed core, constant-true when N is a power of two
    generate
        if (N_CORES == (1 << CORE_W)) begin : g_full
            assign core_ok = 1'b1;
        end else begin : g_part
            assign core_ok = (int'(acc_core) < N_CORES);
        end
    endgenerate

    assign dst_raw  = bus_wdata[IDX_MSB:IDX_LSB];
    assign dst_ok   = (int'(dst_raw) < N_CORES);
    assign dst_core = dst_raw[CORE_W-1:0];
    assign cmd_data = bus_wdata[DATA_W-1:0];

    // Qualify a command write and its two flags
    always_comb begin
        cmd_wr   = bus_we && aligned && core_ok && !sel_mbox;
        cmd_ack  = cmd_wr && bus_wdata[BIT_ACK];
        cmd_send = cmd_wr && bus_wdata[BIT_SEND] && dst_ok;
    end

endmodule

// File: rtl/ipi_mbox_slot.sv
// Module: one core's mailbox register. A send that targets this slot wins
// over an acknowledge in the same cycle (acknowledge first, then send).
module ipi_mbox_slot
    import ipi_mbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack_own,
    input  logic              send_hit,
    input  logic [IDX_W-1:0]  src_idx,
    input  logic [DATA_W-1:0] payload,
    output mbox_t             mbox
);

    // Hold, load on send, or drop the pending flag on acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mbox <= '0;
        end else if (send_hit) begin
            mbox.pend <= 1'b1;
            mbox.src  <= src_idx;
            mbox.data <= payload;
        end else if (ack_own) begin
            mbox.pend <= 1'b0;
        end
    end

endmodule

// File: rtl/ipi_read_mux.sv
// Module: read data path. Only aligned, in-range mailbox words return data;
// command words and everything else read zero.
module ipi_read_mux
    import ipi_mbox_pkg::*;
#(
    parameter int N_CORES = 4,
    localparam int CORE_W = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
    input  logic              aligned,
    input  logic              core_ok,
    input  logic              sel_mbox,
    input  logic [CORE_W-1:0] acc_core,
    input  mbox_t             mbox [N_CORES],
    output logic [WORD_W-1:0] rdata
);

    // Select the addressed mailbox word or return zero
    always_comb begin
        rdata = '0;
        if (aligned && core_ok && sel_mbox) begin
            rdata = mbox_word(mbox[acc_core]);
        end
    end

endmodule

// File: rtl/ipi_mailbox.sv
// Module: top of the inter-core doorbell. Each core has a command word at
// core*8 and a mailbox word at core*8+4. Assumes single-cycle writes and
// combinational reads; the interrupt lines come straight from pending flags.
module ipi_mailbox
    import ipi_mbox_pkg::*;
#(
    parameter int N_CORES = 4,
    localparam int CORE_W = (N_CORES > 1) ? $clog2(N_CORES) : 1,
    localparam int ADDR_W = CORE_W + 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [WORD_W-1:0]  bus_wdata,
    output logic [WORD_W-1:0]  bus_rdata,
    output logic [N_CORES-1:0] irq_o
);

    logic              aligned, core_ok, sel_mbox;
    logic [CORE_W-1:0] acc_core, dst_core;
    logic              cmd_wr, cmd_ack, cmd_send;
    logic [DATA_W-1:0] cmd_data;
    logic [IDX_W-1:0]  src_idx;
    mbox_t             mbox [N_CORES];

    ipi_bus_decode #(.N_CORES(N_CORES)) u_dec (
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .aligned  (aligned),
        .core_ok  (core_ok),
        .sel_mbox (sel_mbox),
        .acc_core (acc_core),
        .cmd_wr   (cmd_wr),
        .cmd_ack  (cmd_ack),
        .cmd_send (cmd_send),
        .dst_core (dst_core),
        .cmd_data (cmd_data)
    );

    assign src_idx = IDX_W'(acc_core);

    // One mailbox per core, steered by writer index and destination index
    generate
        for (genvar i = 0; i < N_CORES; i++) begin : g_slot
            logic ack_i, send_i;
            assign ack_i  = cmd_ack  && (acc_core == CORE_W'(i));
            assign send_i = cmd_send && (dst_core == CORE_W'(i));

            ipi_mbox_slot u_slot (
                .clk     (clk),
                .rst_n   (rst_n),
                .ack_own (ack_i),
                .send_hit(send_i),
                .src_idx (src_idx),
                .payload (cmd_data),
                .mbox    (mbox[i])
            );

            assign irq_o[i] = mbox[i].pend;
        end
    endgenerate

    ipi_read_mux #(.N_CORES(N_CORES)) u_rd (
        .aligned (aligned),
        .core_ok (core_ok),
        .sel_mbox(sel_mbox),
        .acc_core(acc_core),
        .mbox    (mbox),
        .rdata   (bus_rdata)
    );

endmodule

// File: rtl/ipi_mailbox_chk.sv
// Module: property checker for the doorbell, attached by bind. Observes
// only the top-level ports.
module ipi_mailbox_chk #(
    parameter int N_CORES = 4,
    localparam int CORE_W = (N_CORES > 1) ? $clog2(N_CORES) : 1,
    localparam int ADDR_W = CORE_W + 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_we,
    input logic [31:0]        bus_wdata,
    input logic [31:0]        bus_rdata,
    input logic [N_CORES-1:0] irq_o
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (irq_o == '0));

    // R2
    rise_needs_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(irq_o & ~$past(irq_o))) |-> $past(bus_we && bus_wdata[30]));

    // R4
    fall_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~irq_o & $past(irq_o))) |-> $past(bus_we && bus_wdata[31]));

    // R5
    bad_dst_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !bus_addr[2] && bus_wdata[30] && !bus_wdata[31]
         && (int'(bus_wdata[29:16]) >= N_CORES)) |=> $stable(irq_o));

    // R8
    cmd_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_addr[2] |-> (bus_rdata == 32'h0));

    // R8
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[31] == 1'b0);

    // R9
    mbox_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr[2]) |=> $stable(irq_o));

endmodule

bind ipi_mailbox ipi_mailbox_chk #(.N_CORES(N_CORES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq_o    (irq_o)
);

// File: tb/sim_ipi_mailbox.sv
`timescale 1ns/1ps
// Directed bench for the doorbell with four cores.
module sim_ipi_mailbox;

    localparam int N = 4;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  irq_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    ipi_mailbox #(.N_CORES(N)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [AW-1:0] a, input logic [31:0] exp,
                          input string tag);
        bus_addr = a;
        #1;
        checks++;
        if (bus_rdata !== exp) begin
            errors++;
            $display("FAIL %s addr %0d got %h exp %h", tag, a, bus_rdata, exp);
        end
    endtask

    task automatic irq_chk(input logic [N-1:0] exp, input string tag);
        checks++;
        if (irq_o !== exp) begin
            errors++;
            $display("FAIL %s irq got %b exp %b", tag, irq_o, exp);
        end
    endtask

    task automatic t_reset();
        for (int c = 0; c < N; c++) rd_chk(AW'(c*8+4), 32'h0, "R1");
        irq_chk('0, "R1");
    endtask

    task automatic t_send();
        wr(5'd8, 32'h4002_BEEF);            // core1 -> core2
        rd_chk(5'd20, 32'h4001_BEEF, "R2");
        irq_chk(4'b0100, "R2");
        repeat (3) @(negedge clk);
        irq_chk(4'b0100, "R3");
    endtask

    task automatic t_overwrite();
        wr(5'd24, 32'h4002_1234);           // core3 -> core2
        rd_chk(5'd20, 32'h4003_1234, "R6");
        irq_chk(4'b0100, "R6");
    endtask

    task automatic t_ack();
        wr(5'd0, 32'h8000_0000);            // core0 acks, nothing for it
        irq_chk(4'b0100, "R4");
        wr(5'd16, 32'h8000_0000);           // core2 acks
        rd_chk(5'd20, 32'h0003_1234, "R4");
        irq_chk(4'b0000, "R4");
    endtask

    task automatic t_bad_dst();
        wr(5'd0, 32'h4004_0055);
        irq_chk(4'b0000, "R5");
        wr(5'd0, 32'h7FFF_0055);
        irq_chk(4'b0000, "R5");
        rd_chk(5'd4, 32'h0, "R5");
    endtask

    task automatic t_both();
        wr(5'd8, 32'hC001_00AA);            // core1 ack+send to itself
        rd_chk(5'd12, 32'h4001_00AA, "R7");
        irq_chk(4'b0010, "R7");
        wr(5'd8, 32'hC003_0077);            // core1 ack+send to core3
        rd_chk(5'd12, 32'h0001_00AA, "R7");
        rd_chk(5'd28, 32'h4001_0077, "R7");
        irq_chk(4'b1000, "R7");
    endtask

    task automatic t_mbox_write();
        wr(5'd28, 32'h0);
        wr(5'd4, 32'hFFFF_FFFF);
        rd_chk(5'd28, 32'h4001_0077, "R9");
        rd_chk(5'd4, 32'h0, "R9");
        irq_chk(4'b1000, "R9");
    endtask

    task automatic t_ctrl_read();
        rd_chk(5'd24, 32'h0, "R8");
        rd_chk(5'd8, 32'h0, "R8");
    endtask

    task automatic t_noop();
        wr(5'd0, 32'h0002_FFFF);
        rd_chk(5'd20, 32'h0003_1234, "R10");
        irq_chk(4'b1000, "R10");
    endtask

    task automatic t_misaligned();
        wr(5'd9, 32'h4000_0011);            // would send core1 -> core0
        irq_chk(4'b1000, "R11");
        rd_chk(5'd29, 32'h0, "R11");
        rd_chk(5'd4, 32'h0, "R11");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_send();
        t_overwrite();
        t_ack();
        t_bad_dst();
        t_both();
        t_mbox_write();
        t_ctrl_read();
        t_noop();
        t_misaligned();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule